// File: doc/BRIEF.md
# System Clock Source Select and Bus Prescaler Tree

This block chooses which of several high-frequency sources drives the system clock and derives three bus clocks from that choice. Each derived clock is presented as a one-cycle enable pulse in the domain of the selected source. The enables are a system enable, a high-speed bus enable, a peripheral bus enable and a low-speed peripheral enable. Downstream logic gates its registers with these pulses instead of using separate clock nets.

Software-style configuration arrives on a single write strobe that carries three fields: a source code, a high-speed prescaler code and a peripheral prescaler code. A source code that names no existing source falls back to the internal fast RC oscillator, which is also the source selected at reset. The selection that is actually in effect is returned on a readback port and as a one-hot select. New prescaler values take hold at once. A deep-sleep input stops every derived enable for as long as it is high.

Top module: `sysclk_tree`

## Requirements
- R1: While reset is held and during the two synchronising cycles after it is released, all enables are low and `eff_src` reads 0, the fast RC source. After that, with no write, `hclk_en` and `pclk_en` pulse every cycle and `lsclk_en` pulses every second cycle.
- R2: A written source code below NSRC (default 4) is reported unchanged on `eff_src` from the cycle after the write edge. Any code of NSRC or above is reported as 0. In both cases `src_onehot` has exactly the bit of `eff_src` set.
- R3: `cfg_hpre` selects the high-speed ratio: 0 gives divide by 1, 1 gives divide by 2, 2 gives divide by 4, and the reserved code 3 gives divide by 1.
- R4: `cfg_ppre` selects the peripheral ratio applied to high-speed pulses: 1 gives divide by 2, and 0, 2 and 3 give divide by 1. `pclk_en` is high only together with `hclk_en`.
- R5: `lsclk_en` is high on every second `pclk_en` pulse and never without `pclk_en`. There is no setting for this ratio.
- R6: A write that changes the decoded high-speed or peripheral ratio restarts all divide counters. In the cycle after the write edge, all three bus enables are high, and the new ratios apply from that cycle onward.
- R7: A write that leaves both decoded ratios unchanged does not disturb the pulse phase.
- R8: While `deep_sleep` is high, `sysclk_en` and all bus enables are low. In the first cycle with `deep_sleep` low again, all three bus enables are high.
- R9: Each enable is high for exactly one cycle per divided period. With high-speed ratio H and peripheral ratio P, the pulses counted from a restart occur at cycle k when k mod H, k mod H·P and k mod 2·H·P are 0, respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Selected source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| deep_sleep | input | 1 | Stops all derived enables while high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_src | input | SELW | Requested source code |
| cfg_hpre | input | 2 | High-speed prescaler code |
| cfg_ppre | input | 2 | Peripheral prescaler code |
| eff_src | output | SELW | Source code in effect |
| src_onehot | output | NSRC | One-hot select of the source in effect |
| sysclk_en | output | 1 | System clock running |
| hclk_en | output | 1 | High-speed bus enable pulse |
| pclk_en | output | 1 | Peripheral bus enable pulse |
| lsclk_en | output | 1 | Low-speed peripheral enable pulse |

## Verification
The configuration registers and divide counters update on the write edge. The enables are decoded from the counters without a further register, so readback and the first pulse at the new ratio are both due in the cycle that follows the write edge. The bench releases the strobe and samples at the falling edge after the write. From there it counts cycle offsets k and compares each enable against the k-mod pattern for that offset. Deep-sleep gating is combinational, so the bench checks it one time unit after the input changes. The phase-keeping check compares the offset against the preceding restart, not against the write.

// File: rtl/sctree_pkg.sv
package sctree_pkg;

  typedef logic [1:0] div_log2_t;

  // High-speed prescaler code to log2 of ratio; reserved code maps to divide by 1.
  function automatic div_log2_t hpre_to_log2(input logic [1:0] code);
    case (code)
      2'd1:    hpre_to_log2 = 2'd1;
      2'd2:    hpre_to_log2 = 2'd2;
      default: hpre_to_log2 = 2'd0;
    endcase
  endfunction

  // Peripheral prescaler code: only code 1 halves.
  function automatic div_log2_t ppre_to_log2(input logic [1:0] code);
    ppre_to_log2 = (code == 2'd1) ? 2'd1 : 2'd0;
  endfunction

endpackage

// File: rtl/sctree_rstsync.sv
module sctree_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/sctree_cfg.sv
module sctree_cfg
  import sctree_pkg::*;
#(
  parameter int NSRC        = 4,
  parameter int SELW        = 3,
  parameter int DEFAULT_SRC = 0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [SELW-1:0] cfg_src,
  input  logic [1:0]      cfg_hpre,
  input  logic [1:0]      cfg_ppre,
  output logic [SELW-1:0] src_q,
  output div_log2_t       hlog2_q,
  output div_log2_t       plog2_q,
  output logic            ratio_chg
);
  localparam logic [SELW-1:0] DEF_CODE = SELW'(DEFAULT_SRC);
  localparam logic [SELW:0]   NSRC_W   = (SELW+1)'(NSRC);

  logic [SELW-1:0] src_d;
  div_log2_t       hlog2_d, plog2_d, hlog2_new, plog2_new;

  always_comb begin
    hlog2_new = hpre_to_log2(cfg_hpre);
    plog2_new = ppre_to_log2(cfg_ppre);
    ratio_chg = cfg_we && ((hlog2_new != hlog2_q) || (plog2_new != plog2_q));
    src_d     = src_q;
    hlog2_d   = hlog2_q;
    plog2_d   = plog2_q;
    if (cfg_we) begin
      src_d   = ({1'b0, cfg_src} < NSRC_W) ? cfg_src : DEF_CODE;
      hlog2_d = hlog2_new;
      plog2_d = plog2_new;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q   <= DEF_CODE;
      hlog2_q <= '0;
      plog2_q <= '0;
    end else begin
      src_q   <= src_d;
      hlog2_q <= hlog2_d;
      plog2_q <= plog2_d;
    end
  end
endmodule

// File: rtl/sctree_div.sv
module sctree_div
  import sctree_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick_in,
  input  logic      restart,
  input  div_log2_t log2_ratio,
  output logic      tick_out
);
  logic [1:0] cnt_q, cnt_d, last;

  always_comb begin
    last  = 2'((3'd1 << log2_ratio) - 3'd1);
    cnt_d = cnt_q;
    if (restart)      cnt_d = '0;
    else if (tick_in) cnt_d = (cnt_q == last) ? 2'd0 : cnt_q + 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick_out = tick_in && (cnt_q == 2'd0);
endmodule

// File: rtl/sysclk_tree.sv
module sysclk_tree
  import sctree_pkg::*;
#(
  parameter int NSRC        = 4,
  parameter int SELW        = 3,
  parameter int DEFAULT_SRC = 0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            deep_sleep,
  input  logic            cfg_we,
  input  logic [SELW-1:0] cfg_src,
  input  logic [1:0]      cfg_hpre,
  input  logic [1:0]      cfg_ppre,
  output logic [SELW-1:0] eff_src,
  output logic [NSRC-1:0] src_onehot,
  output logic            sysclk_en,
  output logic            hclk_en,
  output logic            pclk_en,
  output logic            lsclk_en
);
  localparam int NSTAGE = 3;

  logic      rst_sync_n, run, ratio_chg, restart;
  div_log2_t hlog2, plog2;
  div_log2_t      stage_log2 [NSTAGE];
  logic [NSTAGE:0] ticks;

  sctree_rstsync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  sctree_cfg #(.NSRC(NSRC), .SELW(SELW), .DEFAULT_SRC(DEFAULT_SRC)) u_cfg (
    .clk(clk), .rst_n(rst_sync_n), .cfg_we(cfg_we), .cfg_src(cfg_src),
    .cfg_hpre(cfg_hpre), .cfg_ppre(cfg_ppre), .src_q(eff_src),
    .hlog2_q(hlog2), .plog2_q(plog2), .ratio_chg(ratio_chg)
  );

  assign run       = rst_sync_n && !deep_sleep;
  assign restart   = ratio_chg || !run;
  assign sysclk_en = run;
  assign ticks[0]  = run;

  assign stage_log2[0] = hlog2;
  assign stage_log2[1] = plog2;
  assign stage_log2[2] = 2'd1;   // low-speed stage is a fixed halving

  for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
    sctree_div u_div (
      .clk(clk), .rst_n(rst_sync_n), .tick_in(ticks[g]), .restart(restart),
      .log2_ratio(stage_log2[g]), .tick_out(ticks[g+1])
    );
  end

  assign hclk_en  = ticks[1];
  assign pclk_en  = ticks[2];
  assign lsclk_en = ticks[3];

  always_comb begin
    src_onehot = '0;
    for (int i = 0; i < NSRC; i++)
      if (eff_src == SELW'(i)) src_onehot[i] = 1'b1;
  end
endmodule

// File: rtl/sysclk_tree_chk.sv
module sysclk_tree_chk #(
  parameter int NSRC = 4,
  parameter int SELW = 3
) (
  input logic            clk,
  input logic            rst_sync_n,
  input logic            deep_sleep,
  input logic [SELW-1:0] eff_src,
  input logic [NSRC-1:0] src_onehot,
  input logic            sysclk_en,
  input logic            hclk_en,
  input logic            pclk_en,
  input logic            lsclk_en
);
  a_r2_src_in_range: assert property (@(posedge clk) disable iff (!rst_sync_n)
    int'(eff_src) < NSRC);

  a_r2_onehot_select: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $countones(src_onehot) == 1);

  a_r4_pclk_within_hclk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pclk_en |-> hclk_en);

  a_r5_ls_within_pclk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    lsclk_en |-> pclk_en);

  a_r8_sleep_gates: assert property (@(posedge clk) disable iff (!rst_sync_n)
    deep_sleep |-> (!sysclk_en && !hclk_en && !pclk_en && !lsclk_en));

  a_r8_wake_pulse: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(deep_sleep) && !deep_sleep) |-> (hclk_en && pclk_en && lsclk_en));
endmodule

bind sysclk_tree sysclk_tree_chk #(.NSRC(NSRC), .SELW(SELW)) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .deep_sleep(deep_sleep),
  .eff_src(eff_src), .src_onehot(src_onehot), .sysclk_en(sysclk_en),
  .hclk_en(hclk_en), .pclk_en(pclk_en), .lsclk_en(lsclk_en)
);

// File: tb/tb_sysclk_tree.sv
module tb_sysclk_tree;
  localparam int PERIOD = 10;
  localparam int NSRC = 4;
  localparam int SELW = 3;
  localparam int NVEC = 7;
  localparam int NSAMP = 13;
  // {hpre[1:0], ppre[1:0], src[2:0], expected_src[2:0]}
  localparam logic [9:0] VEC [NVEC] = '{
    {2'd1, 2'd0, 3'd1, 3'd1},
    {2'd2, 2'd1, 3'd3, 3'd3},
    {2'd0, 2'd1, 3'd5, 3'd0},
    {2'd3, 2'd0, 3'd2, 3'd2},
    {2'd2, 2'd0, 3'd7, 3'd0},
    {2'd1, 2'd1, 3'd0, 3'd0},
    {2'd0, 2'd3, 3'd4, 3'd0}
  };

  logic clk = 1'b0, rst_n = 1'b0, deep_sleep = 1'b0, cfg_we = 1'b0;
  logic [SELW-1:0] cfg_src = '0;
  logic [1:0] cfg_hpre = '0, cfg_ppre = '0;
  logic [SELW-1:0] eff_src;
  logic [NSRC-1:0] src_onehot;
  logic sysclk_en, hclk_en, pclk_en, lsclk_en;
  int checks = 0, fails = 0;

  always #(PERIOD/2) clk = ~clk;

  sysclk_tree #(.NSRC(NSRC), .SELW(SELW)) dut (
    .clk(clk), .rst_n(rst_n), .deep_sleep(deep_sleep), .cfg_we(cfg_we),
    .cfg_src(cfg_src), .cfg_hpre(cfg_hpre), .cfg_ppre(cfg_ppre),
    .eff_src(eff_src), .src_onehot(src_onehot), .sysclk_en(sysclk_en),
    .hclk_en(hclk_en), .pclk_en(pclk_en), .lsclk_en(lsclk_en)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Write at a falling edge, strobe over one rising edge, return at next falling edge.
  task automatic write_cfg(input logic [1:0] h, input logic [1:0] p, input logic [SELW-1:0] s);
    cfg_hpre = h; cfg_ppre = p; cfg_src = s; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  initial begin
    #(PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1 src in reset", int'(eff_src), 0);
    check("R1 hclk in reset", int'(hclk_en), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 sync hold", int'(hclk_en | sysclk_en), 0);
    repeat (3) @(negedge clk);
    begin
      int hm = 0, pm = 0, lc = 0;
      for (int k = 0; k < 8; k++) begin
        if (!hclk_en) hm++;
        if (!pclk_en) pm++;
        if (lsclk_en) lc++;
        @(negedge clk);
      end
      check("R1 hclk every cycle misses", hm, 0);
      check("R1 pclk every cycle misses", pm, 0);
      check("R1 lsclk pulses in 8", lc, 4);
    end

    // Table walk: R2 R3 R4 R5 R6 R9
    for (int v = 0; v < NVEC; v++) begin
      logic [1:0] h, p;
      int hr, pr, hbad, pbad, lbad;
      h = VEC[v][9:8]; p = VEC[v][7:6];
      hr = (h == 2'd1) ? 2 : (h == 2'd2) ? 4 : 1;
      pr = (p == 2'd1) ? 2 : 1;
      write_cfg(h, p, VEC[v][5:3]);
      check("R2 eff_src", int'(eff_src), int'(VEC[v][2:0]));
      check("R2 onehot", int'(src_onehot), 1 << VEC[v][2:0]);
      hbad = 0; pbad = 0; lbad = 0;
      for (int k = 0; k < NSAMP; k++) begin
        if (hclk_en != ((k % hr) == 0)) hbad++;
        if (pclk_en != ((k % (hr*pr)) == 0)) pbad++;
        if (lsclk_en != ((k % (2*hr*pr)) == 0)) lbad++;
        @(negedge clk);
      end
      check("R3 R6 R9 hclk pattern mismatches", hbad, 0);
      check("R4 R6 R9 pclk pattern mismatches", pbad, 0);
      check("R5 R6 R9 lsclk pattern mismatches", lbad, 0);
    end

    // R7: same ratios keep phase
    write_cfg(2'd2, 2'd0, 3'd1);          // restart, k=0 now
    check("R6 restart pulse", int'(hclk_en), 1);
    @(negedge clk);                        // k=1
    write_cfg(2'd2, 2'd0, 3'd2);          // no ratio change, now k=2
    check("R7 no restart k2", int'(hclk_en), 0);
    check("R2 src after same-ratio write", int'(eff_src), 2);
    @(negedge clk);
    check("R7 no pulse k3", int'(hclk_en), 0);
    @(negedge clk);
    check("R7 pulse k4", int'(hclk_en), 1);

    // R8 deep sleep
    @(negedge clk);
    deep_sleep = 1'b1;
    #1;
    check("R8 sysclk stopped", int'(sysclk_en), 0);
    check("R8 enables stopped", int'({hclk_en, pclk_en, lsclk_en}), 0);
    repeat (3) @(negedge clk);
    check("R8 still stopped", int'({sysclk_en, hclk_en, pclk_en, lsclk_en}), 0);
    deep_sleep = 1'b0;
    #1;
    check("R8 wake pulse", int'({sysclk_en, hclk_en, pclk_en, lsclk_en}), 15);
    @(negedge clk);
    check("R8 R9 after wake k1", int'(hclk_en), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule